// File: doc/BRIEF.md
# Mailbox Receive Queue with Raw Pointer Status

This block is the receive side of an inter-processor mailbox. Remote senders push 64-bit messages, each tagged with a 3-bit source channel, through a simple push port. The messages are stored in a circular queue. The host drains the queue through a small register window. It reads the oldest entry through three read-only registers, and the entry stays in place until the host writes a trigger that moves the read position forward.

The block does not report the fill level as a count. Software reads the raw write and read positions and a full bit, and works out the level itself. When the two positions are equal, the full bit tells a full queue from an empty one. When the read position is ahead of the write position, the queue has wrapped, and the level is the depth minus the read position plus the write position.

A pending flag is set whenever the queue holds data. It drives the interrupt output only while mask bit 0 is low. The host clears the flag with a register write. Register reads are combinational on the address. Writes take effect at the clock edge.

Top module: `mbox_rx_queue`

## Requirements
- R1: After reset the status register reads 0, the mask register reads 5'h1F, the pending bit reads 0 and `irq` is low.
- R2: An accepted push stores the message at the write position and advances that position by one. Status bits [23:16] hold the write position, bits [31:24] hold the read position and bit 0 holds the full flag. All other status bits read 0.
- R3: Offset 0x00 returns the head entry's channel in bits [2:0], offset 0x04 returns data bits [31:0] and offset 0x08 returns data bits [63:32]. These reads do not remove the entry.
- R4: A write to offset 0x0C with bit 0 set advances the read position when the queue is not empty. The same write to an empty queue changes nothing.
- R5: The full flag is set exactly when DEPTH entries are held. A push while the queue is full is dropped and leaves the write position unchanged.
- R6: Both positions wrap modulo DEPTH, which is a power of two with a default of 8.
- R7: Writing 0 to offset 0x10 returns both positions and the full flag to 0. Writing any nonzero value there has no effect.
- R8: Offset 0x24 reads DEPTH-1.
- R9: The pending bit (offset 0x18, bit 0) is set on the cycle after any cycle in which the queue is not empty. `irq` equals pending AND NOT mask bit 0. The mask is the 5-bit field at offset 0x1C.
- R10: Writing 1 to bit 0 of offset 0x18 clears pending. If the queue is still not empty, pending is set again one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Sender offers a message this cycle |
| push_data | input | 64 | Message payload |
| push_chan | input | 3 | Source channel tag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| irq | output | 1 | Not-empty interrupt |

## Verification
The bench drives the queue past full and checks that the extra message is dropped. A design that stored it anyway would overwrite the head or leave the write position on the wrong slot. It then drains and refills the queue so that the write position wraps behind the read position, which catches a position counter that saturates or loses the full flag when the pointers meet. It triggers a pop on an empty queue, which would expose a read position that moves without data. It also clears the pending flag while data remains, so that a flag that never re-arms, or one that ignores the clear, shows up in the cycle-exact comparison with the model.

// File: rtl/mbox_rx_queue.sv
module mbox_rx_queue #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_valid,
  input  logic [63:0] push_data,
  input  logic [2:0]  push_chan,
  input  logic        reg_wr,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);

  logic [66:0]   mem [DEPTH];
  logic [AW-1:0] wr_pos, rd_pos;
  logic          full, pend;
  logic [4:0]    mask;

  wire empty   = (wr_pos == rd_pos) && !full;
  wire push_ok = push_valid && !full;
  wire pop     = reg_wr && reg_addr == 6'h0C && reg_wdata[0] && !empty;
  wire q_rst   = reg_wr && reg_addr == 6'h10 && reg_wdata == 32'd0;
  wire clr     = reg_wr && reg_addr == 6'h18 && reg_wdata[0];
  wire [AW-1:0] wr_nxt = wr_pos + 1'b1;
  wire [66:0]   head   = mem[rd_pos];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_pos] <= {push_chan, push_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pos <= '0;
      rd_pos <= '0;
      full   <= 1'b0;
    end else if (q_rst) begin
      wr_pos <= '0;
      rd_pos <= '0;
      full   <= 1'b0;
    end else begin
      if (push_ok) wr_pos <= wr_nxt;
      if (pop)     rd_pos <= rd_pos + 1'b1;
      if (push_ok && !pop && wr_nxt == rd_pos) full <= 1'b1;
      else if (pop && !push_ok)                full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      mask <= 5'h1F;
    end else begin
      pend <= clr ? 1'b0 : (pend | !empty);
      if (reg_wr && reg_addr == 6'h1C) mask <= reg_wdata[4:0];
    end
  end

  assign irq = pend && !mask[0];

  always_comb begin
    case (reg_addr)
      6'h00:   reg_rdata = {29'd0, head[66:64]};
      6'h04:   reg_rdata = head[31:0];
      6'h08:   reg_rdata = head[63:32];
      6'h14:   reg_rdata = {8'(rd_pos), 8'(wr_pos), 15'd0, full};
      6'h18:   reg_rdata = {31'd0, pend};
      6'h1C:   reg_rdata = {27'd0, mask};
      6'h24:   reg_rdata = 32'(DEPTH - 1);
      default: reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/mbox_rx_queue_chk.sv
module mbox_rx_queue_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_valid,
  input logic          reg_wr,
  input logic [5:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          irq,
  input logic [AW-1:0] wr_pos,
  input logic [AW-1:0] rd_pos,
  input logic          full,
  input logic          pend,
  input logic [4:0]    mask
);
  wire is_empty = (wr_pos == rd_pos) && !full;
  wire trig = reg_wr && reg_addr == 6'h0C && reg_wdata[0];
  wire rstw = reg_wr && reg_addr == 6'h10 && reg_wdata == 32'd0;
  wire clrw = reg_wr && reg_addr == 6'h18 && reg_wdata[0];

  assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    full && push_valid && !trig && !rstw |=> $stable(wr_pos));
  assert_full_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> wr_pos == rd_pos);
  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_empty && trig && !rstw |=> $stable(rd_pos));
  assert_qreset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rstw |=> wr_pos == '0 && rd_pos == '0 && !full);
  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend && !mask[0]);
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clrw |=> !pend);
  assert_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !is_empty && !clrw |=> pend);
endmodule

bind mbox_rx_queue mbox_rx_queue_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq(irq), .wr_pos(wr_pos),
  .rd_pos(rd_pos), .full(full), .pend(pend), .mask(mask)
);

// File: tb/test_mbox_rx_queue.sv
module test_mbox_rx_queue;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic [63:0] push_data = '0;
  logic [2:0]  push_chan = '0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  always #10 clk = ~clk;

  mbox_rx_queue #(.DEPTH(DEPTH)) i_mbox_rx_queue (.*);

  int checks = 0, errors = 0;
  logic [66:0] q[$];
  int mwr = 0, mrd = 0;
  bit mpend = 0;
  logic [4:0] mmask = 5'h1F;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] exp_status();
    return {8'(mrd), 8'(mwr), 15'd0, q.size() == DEPTH};
  endfunction

  task automatic compare(string tag);
    logic [31:0] d;
    rd(6'h14, d);
    check(tag, d, exp_status());
    rd(6'h18, d);
    check("R9 pending", d, {31'd0, mpend});
    check("R9 irq", {31'd0, irq}, {31'd0, mpend && !mmask[0]});
  endtask

  task automatic step(bit p, logic [63:0] dat, logic [2:0] ch, bit w,
                      logic [5:0] a, logic [31:0] wd, string tag);
    bit e0, f0;
    @(negedge clk);
    push_valid = p; push_data = dat; push_chan = ch;
    reg_wr = w; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    e0 = q.size() == 0;
    f0 = q.size() == DEPTH;
    if (w && a == 6'h10 && wd == 0) begin
      q.delete(); mwr = 0; mrd = 0;
    end else begin
      if (w && a == 6'h0C && wd[0] && !e0) begin
        void'(q.pop_front()); mrd = (mrd + 1) % DEPTH;
      end
      if (p && !f0) begin
        q.push_back({ch, dat}); mwr = (mwr + 1) % DEPTH;
      end
    end
    mpend = (w && a == 6'h18 && wd[0]) ? 1'b0 : (mpend | !e0);
    if (w && a == 6'h1C) mmask = wd[4:0];
    #1;
    push_valid = 1'b0; reg_wr = 1'b0;
    compare(tag);
  endtask

  task automatic push(logic [63:0] d, logic [2:0] c, string tag);
    step(1, d, c, 0, 6'h00, 0, tag);
  endtask
  task automatic pop(string tag);
    step(0, 0, 0, 1, 6'h0C, 1, tag);
  endtask
  task automatic wreg(logic [5:0] a, logic [31:0] d, string tag);
    step(0, 0, 0, 1, a, d, tag);
  endtask
  task automatic idle(string tag);
    step(0, 0, 0, 0, 6'h00, 0, tag);
  endtask

  task automatic check_head(string tag);
    logic [31:0] d;
    if (q.size() == 0) return;
    rd(6'h00, d); check({tag, " chan"}, d, {29'd0, q[0][66:64]});
    rd(6'h04, d); check({tag, " low"},  d, q[0][31:0]);
    rd(6'h08, d); check({tag, " high"}, d, q[0][63:32]);
  endtask

  bit done = 0;
  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    rd(6'h14, d); check("R1 status", d, 32'd0);
    rd(6'h1C, d); check("R1 mask", d, 32'h1F);
    rd(6'h18, d); check("R1 pending", d, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    // R8 depth register
    rd(6'h24, d); check("R8 depth", d, DEPTH - 1);

    // R2 pushes; R9 pending while masked
    push(64'hA5A5_0001_1234_5678, 3'd5, "R2");
    check_head("R3");
    push(64'h0BAD_F00D_CAFE_0002, 3'd2, "R2");
    push(64'h1111_2222_3333_0003, 3'd7, "R2");
    check_head("R3");
    check_head("R3 reread");
    // R9 unmask
    wreg(6'h1C, 32'h1E, "R9");
    // R10 clear while data remains: low one cycle, then re-set
    wreg(6'h18, 32'h1, "R10");
    idle("R10");
    // R4 pops
    pop("R4"); check_head("R3");
    pop("R4"); check_head("R3");
    pop("R4");
    pop("R4 empty trigger");
    step(0, 0, 0, 1, 6'h0C, 32'h2, "R4 bit0 clear");
    wreg(6'h18, 32'h1, "R10");
    idle("R10 stays clear");
    // R5 fill to full, then overflow
    for (int i = 0; i < DEPTH; i++)
      push({32'hFEED0000 + 32'(i), 32'h0 + 32'(i * 3)}, 3'(i), "R5");
    push(64'hDEAD_DEAD_DEAD_DEAD, 3'd1, "R5 drop");
    push(64'hDEAD_DEAD_DEAD_DEAD, 3'd1, "R5 drop");
    check_head("R5");
    // R6 wrap: pop 3, push 2, simultaneous push and pop
    pop("R6"); pop("R6"); pop("R6");
    push(64'h6666_0000_0000_0001, 3'd3, "R6");
    push(64'h6666_0000_0000_0002, 3'd4, "R6");
    step(1, 64'h6666_0000_0000_0003, 3'd6, 1, 6'h0C, 1, "R6 push+pop");
    check_head("R6");
    rd(6'h14, d); check("R6 wrapped pointers", d, exp_status());
    // R7 nonzero write ignored, zero write resets
    wreg(6'h10, 32'h1, "R7 ignored");
    check_head("R7");
    wreg(6'h10, 32'h0, "R7 reset");
    rd(6'h14, d); check("R7 cleared", d, 32'd0);
    push(64'h7777_7777_0000_0001, 3'd0, "R7 after reset");
    check_head("R7");
    // R9 mask all ones again
    wreg(6'h1C, 32'h1F, "R9 masked");
    idle("R9");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule